// File: doc/BRIEF.md
# Paged NVRAM IO-Bus Bridge

This block sits on the slave side of a 32-bit memory-mapped window and serves six narrow 16-bit peripheral slots. Address bits [15:12] select a slot, and bits [8:4] select one of 32 registers inside it. One slot is a page register. Another slot is a 32-entry window into a byte-wide non-volatile store. That store is modelled by an internal synchronous byte array. Two slots hold plain 16-bit stub registers. The two remaining slots are unpopulated.

Bus accesses can be 1, 2 or 4 bytes wide. A write is narrowed to the slot's 16 bits with byte swapping. A read widens the 16-bit slot value: it is replicated across lanes, shifted by the byte offset and byte swapped to suit the access size. A read request lasts a single cycle. The formatted data comes back one cycle later with a valid strobe. Two error pulses flag writes to absent slots and writes whose low address nibble is not zero.

The control is a two-state machine:
- **ST_IDLE** moves to **ST_RESP** on any read request ("read accepted"). It stays in ST_IDLE on a write or when there is no request.
- **ST_RESP** drives the response. It goes back to ST_IDLE when no read arrives ("response done"). It stays in ST_RESP when another read arrives in the same cycle ("back-to-back read").

Top module: `nvpage_bridge`

## Requirements
- R1: Address bits [15:12] equal to 0xA..0xF select slot 0..5, and bits [8:4] give the register index. Any other [15:12] value counts as an absent slot.
- R2: Slot 3 (0xD) is a 16-bit page register. It resets to 0 and changes only on a write to that slot.
- R3: Slot 5 (0xF) reaches the byte array at address ((page << 5) + index) modulo NV_BYTES.
- R4: The 16-bit write value depends on req_size. Size 1 gives {8'h00, wdata[7:0]}. Size 2 gives {wdata[7:0], wdata[15:8]}. Size 4 gives {wdata[23:16], wdata[31:24]}. Any other size gives 0.
- R5: For a read, the slot value v is widened to the 64-bit word {16'h0, v, 16'h0, v} and shifted right by addr[1:0]*8; call the result s. Size 1 returns s[7:0] zero-extended. Size 2 returns {s[7:0], s[15:8]} zero-extended. Size 4 returns the byte swap of s[31:0]. Any other size returns 0.
- R6: rsp_valid is high exactly in the cycle after each read request, with rsp_rdata valid in that cycle. Writes produce no response.
- R7: Slots 0 (0xA) and 2 (0xC) are 16-bit stub registers, and the register index is ignored. A read from slot 1 (0xB) or slot 4 (0xE) returns 0.
- R8: A write to an absent slot changes no state, and err_absent pulses for one cycle in the cycle after that write.
- R9: A write with addr[3:0] != 0 pulses err_misalign in the cycle after it, and the write still takes effect.
- R10: A write to the NVRAM window stores the low byte of the 16-bit write value. A read from the window returns that byte zero-extended to 16 bits before formatting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_addr | input | 16 | Window offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Formatted read data |
| err_absent | output | 1 | Pulse: a write hit an absent slot |
| err_misalign | output | 1 | Pulse: a write had a nonzero low nibble |

## Verification
The bench builds the bridge with NV_BYTES = 1024 and leaves the other parameters at their defaults. With that store size, only five page bits take part in the byte address. This lets the bench write through page 0xFFFF and read the same byte back through page 0x001F, which tests the modulo wrap of R3 in a few cycles. The default slot map places the stub, absent, page and window slots so that every decode branch is reached.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } nvb_state_e;

    // Narrow a bus write to the 16-bit slot value (R4)
    function automatic logic [15:0] narrow_write(input logic [2:0] size, input logic [31:0] d);
        logic [15:0] v;
        unique case (size)
            3'd1:    v = {8'h00, d[7:0]};
            3'd2:    v = {d[7:0], d[15:8]};
            3'd4:    v = {d[23:16], d[31:24]};
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/nvb_slot_decode.sv
module nvb_slot_decode #(
    parameter int SLOTS = 6,
    parameter int IDX_W = 5
) (
    input  logic [3:0]       sel_nib,
    input  logic [IDX_W-1:0] idx_bits,
    input  logic [3:0]       low_nib,
    output logic             hit,
    output logic [2:0]       slot,
    output logic [IDX_W-1:0] ridx,
    output logic             low_nz
);
    localparam logic [3:0] FIRST_SEL = 4'(16 - SLOTS);

    always_comb begin
        hit    = (sel_nib >= FIRST_SEL);
        slot   = hit ? 3'(sel_nib - FIRST_SEL) : 3'd0;
        ridx   = idx_bits;
        low_nz = (low_nib != 4'h0);
    end
endmodule

// File: rtl/nvb_nv_store.sv
module nvb_nv_store #(
    parameter int NV_BYTES = 4096,
    localparam int NV_AW = $clog2(NV_BYTES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [NV_AW-1:0] addr,
    input  logic [7:0]       wbyte,
    output logic [7:0]       rbyte
);
    logic [7:0] cells [NV_BYTES];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wbyte;
        rbyte <= cells[addr];
    end
endmodule

// File: rtl/nvb_rd_format.sv
module nvb_rd_format (
    input  logic [15:0] slot_val,
    input  logic [2:0]  size,
    input  logic [1:0]  offset,
    output logic [31:0] data
);
    logic [63:0] replicated;
    logic [31:0] window;

    always_comb begin
        replicated = {16'h0000, slot_val, 16'h0000, slot_val};
        window     = 32'(replicated >> {offset, 3'b000});
        unique case (size)
            3'd1:    data = {24'h0, window[7:0]};
            3'd2:    data = {16'h0, window[7:0], window[15:8]};
            3'd4:    data = {window[7:0], window[15:8], window[23:16], window[31:24]};
            default: data = 32'h0;
        endcase
    end
endmodule

// File: rtl/nvpage_bridge.sv
module nvpage_bridge #(
    parameter int         NV_BYTES  = 4096,
    parameter int         PAGE_SLOT = 3,
    parameter int         NV_SLOT   = 5,
    parameter logic [5:0] STUB_MASK = 6'b000101
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_size,
    input  logic [15:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        err_absent,
    output logic        err_misalign
);
    import nvb_pkg::*;

    localparam int         SLOTS    = 6;
    localparam int         IDX_W    = 5;
    localparam int         NV_AW    = $clog2(NV_BYTES);
    localparam logic [2:0] PAGE_IDX = PAGE_SLOT[2:0];
    localparam logic [2:0] NV_IDX   = NV_SLOT[2:0];

    nvb_state_e state_q;

    logic             hit, low_nz;
    logic [2:0]       slot;
    logic [IDX_W-1:0] ridx;
    logic             unused_addr_bits;

    assign unused_addr_bits = ^req_addr[11:9];

    nvb_slot_decode #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_dec (
        .sel_nib (req_addr[15:12]),
        .idx_bits(req_addr[8:4]),
        .low_nib (req_addr[3:0]),
        .hit     (hit),
        .slot    (slot),
        .ridx    (ridx),
        .low_nz  (low_nz)
    );

    logic        wr_fire, rd_fire;
    logic        is_page, is_nv, is_stub, present;
    logic [15:0] wval;

    always_comb begin
        wr_fire = req_valid && req_write;
        rd_fire = req_valid && !req_write;
        is_page = hit && (slot == PAGE_IDX);
        is_nv   = hit && (slot == NV_IDX);
        is_stub = hit && STUB_MASK[slot];
        present = is_page || is_nv || is_stub;
        wval    = narrow_write(req_size, req_wdata);
    end

    // Page register and slot registers
    logic [15:0] page_q;
    logic [15:0] slot_val [SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n)                 page_q <= 16'h0000;
        else if (wr_fire && is_page) page_q <= wval;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (STUB_MASK[g]) begin : g_stub
            logic [15:0] stub_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                                  stub_q <= 16'h0000;
                else if (wr_fire && hit && slot == 3'(g))    stub_q <= wval;
            end
            assign slot_val[g] = stub_q;
        end else if (g == PAGE_SLOT) begin : g_page
            assign slot_val[g] = page_q;
        end else begin : g_none
            assign slot_val[g] = 16'h0000;
        end
    end

    // NVRAM byte store
    logic [NV_AW-1:0] nv_addr;
    logic [7:0]       nv_rbyte;

    assign nv_addr = NV_AW'({page_q, 5'b00000} + {16'h0000, ridx});

    nvb_nv_store #(.NV_BYTES(NV_BYTES)) u_store (
        .clk  (clk),
        .we   (wr_fire && is_nv),
        .addr (nv_addr),
        .wbyte(wval[7:0]),
        .rbyte(nv_rbyte)
    );

    // Read capture and error pulses
    logic        sel_nv_q;
    logic [15:0] reg_val_q;
    logic [2:0]  size_q;
    logic [1:0]  off_q;
    logic        absent_q, misalign_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_nv_q   <= 1'b0;
            reg_val_q  <= 16'h0000;
            size_q     <= 3'd0;
            off_q      <= 2'd0;
            absent_q   <= 1'b0;
            misalign_q <= 1'b0;
        end else begin
            if (rd_fire) begin
                sel_nv_q  <= is_nv;
                reg_val_q <= hit ? slot_val[slot] : 16'h0000;
                size_q    <= req_size;
                off_q     <= req_addr[1:0];
            end
            absent_q   <= wr_fire && !present;
            misalign_q <= wr_fire && low_nz;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= rd_fire ? ST_RESP : ST_IDLE;
    end

    logic [15:0] rd_val16;
    logic [31:0] fmt_data;

    assign rd_val16 = sel_nv_q ? {8'h00, nv_rbyte} : reg_val_q;

    nvb_rd_format u_fmt (
        .slot_val(rd_val16),
        .size    (size_q),
        .offset  (off_q),
        .data    (fmt_data)
    );

    // Output process
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
                rsp_rdata = 32'h0;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = fmt_data;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_rdata = 32'h0;
            end
        endcase
        err_absent   = absent_q;
        err_misalign = misalign_q;
    end

    // Assertions
    p_rsp_follows_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));
    p_read_gets_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    p_absent_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !present) |=> err_absent);
    p_absent_only_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_absent |-> $past(req_valid && req_write));
    p_misalign_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && low_nz) |=> err_misalign);
    p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && is_page) |=> $stable(page_q));
    p_byte_read_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && size_q == 3'd1) |-> (rsp_rdata[31:8] == 24'h0));
endmodule

// File: tb/nvpage_bridge_bench.sv
module nvpage_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [31:0] req_wdata = 32'h0;
    logic        rsp_valid, err_absent, err_misalign;
    logic [31:0] rsp_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    nvpage_bridge #(.NV_BYTES(1024)) u_nvpage_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .err_absent(err_absent), .err_misalign(err_misalign)
    );

    // {write, size, addr, wdata, expected read data}
    localparam int NV = 24;
    localparam logic [83:0] VEC [NV] = '{
        {1'b1, 3'd1, 16'hD000, 32'h0000_0103, 32'h0},          // R2 R4 page=3
        {1'b0, 3'd4, 16'hD000, 32'h0, 32'h0300_0000},          // R5
        {1'b0, 3'd2, 16'hD000, 32'h0, 32'h0000_0300},          // R5
        {1'b0, 3'd1, 16'hD000, 32'h0, 32'h0000_0003},          // R5
        {1'b1, 3'd2, 16'hF020, 32'h0000_1234, 32'h0},          // R3 R4
        {1'b0, 3'd1, 16'hF020, 32'h0, 32'h0000_0012},          // R10
        {1'b1, 3'd4, 16'hF030, 32'hAABB_CCDD, 32'h0},          // R4
        {1'b0, 3'd2, 16'hF030, 32'h0, 32'h0000_AA00},          // R5 R10
        {1'b0, 3'd4, 16'hF033, 32'h0, 32'h00AA_0000},          // R5 offset 3
        {1'b0, 3'd2, 16'hF032, 32'h0, 32'h0},                  // R5 offset 2
        {1'b1, 3'd2, 16'hA010, 32'h0000_BEEF, 32'h0},          // R7 stub
        {1'b0, 3'd2, 16'hA000, 32'h0, 32'h0000_BEEF},          // R7
        {1'b0, 3'd1, 16'hA001, 32'h0, 32'h0000_00EF},          // R5 R7
        {1'b1, 3'd2, 16'hC000, 32'h0000_CAFE, 32'h0},          // R7
        {1'b0, 3'd4, 16'hC000, 32'h0, 32'hCAFE_0000},          // R7
        {1'b0, 3'd4, 16'hB000, 32'h0, 32'h0},                  // R7 absent
        {1'b0, 3'd4, 16'hE010, 32'h0, 32'h0},                  // R7 absent
        {1'b0, 3'd4, 16'h9000, 32'h0, 32'h0},                  // R1 out of range
        {1'b0, 3'd2, 16'hA000, 32'h0, 32'h0000_BEEF},          // R1 slot isolation
        {1'b1, 3'd4, 16'hD000, 32'h0400_0000, 32'h0},          // R4 page=4
        {1'b1, 3'd1, 16'hF020, 32'h0000_005A, 32'h0},          // R3
        {1'b0, 3'd1, 16'hF020, 32'h0, 32'h0000_005A},          // R3
        {1'b1, 3'd1, 16'hD000, 32'h0000_0003, 32'h0},          // R2 page=3
        {1'b0, 3'd1, 16'hF020, 32'h0, 32'h0000_0012}           // R3 old page intact
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic access(input logic w, input logic [2:0] sz, input logic [15:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R8 reset err_absent", 32'(err_absent), 32'h0);
        chk("R9 reset err_misalign", 32'(err_misalign), 32'h0);
        rst_n = 1'b1;
        access(1'b0, 3'd4, 16'hD000, 32'h0);
        chk("R2 page reset value", rsp_rdata, 32'h0);
        chk("R6 valid on read", 32'(rsp_valid), 32'h1);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][83], VEC[i][82:80], VEC[i][79:64], VEC[i][63:32]);
            if (VEC[i][83]) begin
                chk($sformatf("R8 R9 vec%0d flags clear", i), {30'h0, err_absent, err_misalign}, 32'h0);
                chk($sformatf("R6 vec%0d no rsp on write", i), 32'(rsp_valid), 32'h0);
            end else begin
                chk($sformatf("R6 vec%0d rsp_valid", i), 32'(rsp_valid), 32'h1);
                chk($sformatf("R5 vec%0d data", i), rsp_rdata, VEC[i][31:0]);
            end
        end

        // R6: strobe lasts exactly one cycle
        access(1'b0, 3'd1, 16'hD000, 32'h0);
        @(negedge clk);
        chk("R6 single-cycle strobe", 32'(rsp_valid), 32'h0);

        // R8: absent write flagged, nothing stored
        access(1'b1, 3'd2, 16'hB000, 32'h0000_1111);
        chk("R8 err_absent pulse", 32'(err_absent), 32'h1);
        @(negedge clk);
        chk("R8 err_absent one cycle", 32'(err_absent), 32'h0);
        access(1'b0, 3'd2, 16'hB000, 32'h0);
        chk("R8 absent write discarded", rsp_rdata, 32'h0);

        // R9: misaligned write flagged but performed
        access(1'b1, 3'd1, 16'hF045, 32'h0000_0077);
        chk("R9 err_misalign pulse", 32'(err_misalign), 32'h1);
        chk("R9 present slot no absent flag", 32'(err_absent), 32'h0);
        access(1'b0, 3'd1, 16'hF040, 32'h0);
        chk("R9 misaligned write landed", rsp_rdata, 32'h0000_0077);

        // R3: page wrap modulo NV_BYTES (1024 -> only 5 page bits matter)
        access(1'b1, 3'd2, 16'hD000, 32'h0000_FFFF);
        access(1'b1, 3'd1, 16'hF010, 32'h0000_0099);
        access(1'b1, 3'd2, 16'hD000, 32'h0000_1F00);
        access(1'b0, 3'd2, 16'hD000, 32'h0);
        chk("R4 page via size 2", rsp_rdata, 32'h0000_1F00);
        access(1'b0, 3'd1, 16'hF010, 32'h0);
        chk("R3 page alias wrap", rsp_rdata, 32'h0000_0099);

        // R4/R5: unsupported size
        access(1'b0, 3'd3, 16'hD000, 32'h0);
        chk("R5 size 3 read zero", rsp_rdata, 32'h0);
        access(1'b1, 3'd3, 16'hD000, 32'hFFFF_FFFF);
        access(1'b0, 3'd2, 16'hD000, 32'h0);
        chk("R4 size 3 write value zero", rsp_rdata, 32'h0);

        // Back-to-back reads keep the strobe high
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 3'd2; req_addr = 16'hA000;
        @(negedge clk);
        chk("R6 back-to-back first", rsp_rdata, 32'h0000_BEEF);
        req_addr = 16'hC000;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 back-to-back second", rsp_rdata, 32'h0000_CAFE);
        chk("R6 back-to-back valid", 32'(rsp_valid), 32'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule